// File: doc/BRIEF.md
# Descriptor Ring TDM Frame Mover

This block is a bus master that carries one TDM frame per frame tick between host memory and a local TDM port. Host software builds a circular ring of four-word descriptors in memory and hands each one to the engine by setting its ownership flag. The engine then walks the ring one descriptor per tick. For each descriptor it streams a transmit buffer out to the TDM side and stores the received words in a receive buffer. It then writes back timing and retry statistics and returns the descriptor to software.

Software uses two registers. At offset 0 it writes the ring base. At offset 4 it writes a control word that holds the DMA enable, a read-only running flag and a clock-source selection. Two event outputs report the completion of a frame that asked for an interrupt and the case where the next descriptor was still owned by software when its frame came due. When that second case occurs, the engine stops by itself and the ring walk goes back to the start.

Top module: `tdm_ring_dma`

## Requirements
- R1: After reset both registers read 0, `mem_req` is low and `irq_event` is 0.
- R2: Writing the enable (control bit 2) from 0 to 1 while stopped latches the ring base and restarts at descriptor 0; control bit 3 (running) reads 1 from the next cycle.
- R3: A descriptor sits at base + 16*index as status (+0), transmit pointer (+4), receive pointer (+8) and control (+12). Per frame the engine reads control, then the transmit pointer, then the receive pointer. It then reads FRAME_WORDS consecutive transmit words, presenting each on `tdm_tx_data` with `tdm_tx_valid`. It then writes FRAME_WORDS words taken from `tdm_rx_data` to consecutive receive addresses, pulsing `tdm_rx_take` after each sample.
- R4: After the buffers, the engine writes the status word with the cycle count from the start of the control read to the status write, which is (2*FRAME_WORDS+3)*(w+1) when every access takes w wait cycles. It then writes control last. The written control keeps bits 30:16 and 7:0 of the original, clears bit 31 (ownership) and puts into bits 15:8 the number of wait cycles seen before the control write, saturating at 255.
- R5: `irq_event[1]` pulses for one cycle after a descriptor with control bit 1 set is handed back. No pulse follows a descriptor with that bit clear. The two event bits are never high together.
- R6: After a descriptor with control bit 0 (end of ring) is handed back, the next frame uses index 0. Otherwise the next frame uses index+1.
- R7: If the control word read at frame time has bit 31 clear, the engine pulses `irq_event[0]`, clears enable and running, writes nothing to memory and resets the ring index to 0.
- R8: Clearing the enable during a frame lets that frame finish; running stays 1 until the frame is handed back and then drops.
- R9: The clock-source field (control bits 13, 12 and 1; 0 = self, bit 1 = recovered, bits 12 and 1 = slave) reads back as written when the write happens while stopped. A write to this field is ignored while running.
- R10: A frame tick has no effect while the engine is stopped or while a frame is already in progress.
- R11: Once `mem_req` is raised, address, direction and write data stay stable until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset (0 base, 4 control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| frame_tick | input | 1 | One-cycle pulse at each TDM frame |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes on this cycle |
| tdm_tx_valid | output | 1 | Transmit word strobe |
| tdm_tx_data | output | 32 | Transmit word toward the TDM side |
| tdm_rx_data | input | 32 | Current received word from the TDM side |
| tdm_rx_take | output | 1 | Received word was sampled; present the next |
| irq_event | output | 2 | Bit 1 frame done, bit 0 underrun |

## Verification
The bench varies memory wait states frame by frame. An engine that miscounted stalls or kept counting during the control write-back would store a wrong retry field or transfer time, and the saturation case catches a retry field that wraps instead of clamping. It runs the ring across its end-of-ring descriptor and restarts after an underrun from a non-zero index. A design that ignored the end flag or kept the old index would touch the wrong descriptor. It also fires a second tick mid-frame, rewrites the clock field while running, and disables mid-frame. A design that double-processed, accepted the field, or dropped running early would leave an extra descriptor handed back, a changed field, or an early zero in the running bit.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
    localparam int WORD_W  = 32;
    localparam int OWN_B   = 31;
    localparam int EOR_B   = 0;
    localparam int INTR_B  = 1;
    localparam int EN_B    = 2;
    localparam int RUN_B   = 3;
    localparam int EV_UNDER = 0;
    localparam int EV_DONE  = 1;
    localparam logic [WORD_W-1:0] CLKSEL_MASK = 32'h0000_3002;

    typedef enum logic [2:0] {
        S_IDLE, S_RD_CTL, S_RD_TXA, S_RD_RXA, S_RD_TX, S_WR_RX, S_WR_STAT, S_WR_CTL
    } seq_state_e;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] base_act;
        logic        en;
        logic        run;
        logic [2:0]  clk_sel;   // {bit13, bit12, bit1}
    } regs_t;
endpackage

// File: rtl/tdr_ctrl_regs.sv
module tdr_ctrl_regs import tdr_pkg::*; #(
    parameter int AW     = 32,
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              seq_underrun,
    input  logic              seq_halt,
    output logic              en,
    output logic              run,
    output logic              start,
    output logic [AW-1:0]     ring_base
);
    regs_t r_q, r_d;

    always_comb begin
        r_d   = r_q;
        start = 1'b0;
        if (reg_wr && reg_addr == REG_AW'(0))
            r_d.base = reg_wdata;
        if (reg_wr && reg_addr == REG_AW'(4)) begin
            if (!r_q.run)
                r_d.clk_sel = {reg_wdata[13], reg_wdata[12], reg_wdata[1]};
            r_d.en = reg_wdata[EN_B];
            if (reg_wdata[EN_B] && !r_q.en && !r_q.run) begin
                start      = 1'b1;
                r_d.run    = 1'b1;
                r_d.base_act = r_q.base;
            end
        end
        if (seq_halt)
            r_d.run = 1'b0;
        if (seq_underrun) begin
            r_d.en  = 1'b0;
            r_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(0)) begin
            reg_rdata = r_q.base;
        end else if (reg_addr == REG_AW'(4)) begin
            reg_rdata[13]    = r_q.clk_sel[2];
            reg_rdata[12]    = r_q.clk_sel[1];
            reg_rdata[1]     = r_q.clk_sel[0];
            reg_rdata[EN_B]  = r_q.en;
            reg_rdata[RUN_B] = r_q.run;
        end
    end

    assign en        = r_q.en;
    assign run       = r_q.run;
    assign ring_base = r_q.base_act[AW-1:0];
endmodule

// File: rtl/tdr_seq.sv
module tdr_seq import tdr_pkg::*; #(
    parameter int AW          = 32,
    parameter int FRAME_WORDS = 4,
    parameter int IDX_W       = 8,
    parameter int TIME_W      = 32,
    localparam int CNT_W      = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              run,
    input  logic              start,
    input  logic              frame_tick,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [WORD_W-1:0] tdm_rx_data,
    output seq_state_e        st,
    output logic [IDX_W-1:0]  idx,
    output logic [CNT_W-1:0]  cnt,
    output logic [WORD_W-1:0] ctl,
    output logic [AW-1:0]     txa,
    output logic [AW-1:0]     rxa,
    output logic [WORD_W-1:0] rxw,
    output logic [TIME_W-1:0] tmr,
    output logic [7:0]        retry,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_data,
    output logic              rx_take,
    output logic [1:0]        ev,
    output logic              underrun,
    output logic              halt,
    output logic              mem_req
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_WORDS - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] ctl;
        logic [AW-1:0]     txa;
        logic [AW-1:0]     rxa;
        logic [WORD_W-1:0] rxw;
        logic [TIME_W-1:0] tmr;
        logic [7:0]        retry;
        logic              tx_v;
        logic [WORD_W-1:0] tx_d;
        logic              rx_take;
        logic [1:0]        ev;
    } seq_t;

    seq_t s_q, s_d;
    logic timed;

    always_comb begin
        s_d          = s_q;
        s_d.tx_v     = 1'b0;
        s_d.rx_take  = 1'b0;
        s_d.ev       = '0;
        underrun     = 1'b0;
        mem_req      = (s_q.st != S_IDLE);
        halt         = (s_q.st == S_IDLE) && run && !en;
        timed        = (s_q.st == S_RD_CTL) || (s_q.st == S_RD_TXA) || (s_q.st == S_RD_RXA) ||
                       (s_q.st == S_RD_TX)  || (s_q.st == S_WR_RX);
        if (start)
            s_d.idx = '0;
        if (timed)
            s_d.tmr = s_q.tmr + 1'b1;
        if (mem_req && !mem_ack && s_q.st != S_WR_CTL && s_q.retry != 8'hFF)
            s_d.retry = s_q.retry + 1'b1;
        case (s_q.st)
            S_IDLE: if (run && en && frame_tick) begin
                s_d.st    = S_RD_CTL;
                s_d.tmr   = '0;
                s_d.retry = '0;
            end
            S_RD_CTL: if (mem_ack) begin
                s_d.ctl = mem_rdata;
                if (mem_rdata[OWN_B]) begin
                    s_d.st = S_RD_TXA;
                end else begin
                    s_d.st           = S_IDLE;
                    s_d.idx          = '0;
                    s_d.ev[EV_UNDER] = 1'b1;
                    underrun         = 1'b1;
                end
            end
            S_RD_TXA: if (mem_ack) begin
                s_d.txa = mem_rdata[AW-1:0];
                s_d.st  = S_RD_RXA;
            end
            S_RD_RXA: if (mem_ack) begin
                s_d.rxa = mem_rdata[AW-1:0];
                s_d.cnt = '0;
                s_d.st  = S_RD_TX;
            end
            S_RD_TX: if (mem_ack) begin
                s_d.tx_v = 1'b1;
                s_d.tx_d = mem_rdata;
                if (s_q.cnt == LAST) begin
                    s_d.cnt     = '0;
                    s_d.st      = S_WR_RX;
                    s_d.rxw     = tdm_rx_data;
                    s_d.rx_take = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            S_WR_RX: if (mem_ack) begin
                if (s_q.cnt == LAST) begin
                    s_d.st = S_WR_STAT;
                end else begin
                    s_d.cnt     = s_q.cnt + 1'b1;
                    s_d.rxw     = tdm_rx_data;
                    s_d.rx_take = 1'b1;
                end
            end
            S_WR_STAT: if (mem_ack) s_d.st = S_WR_CTL;
            S_WR_CTL: if (mem_ack) begin
                s_d.st          = S_IDLE;
                s_d.ev[EV_DONE] = s_q.ctl[INTR_B];
                s_d.idx         = s_q.ctl[EOR_B] ? '0 : s_q.idx + 1'b1;
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign st       = s_q.st;
    assign idx      = s_q.idx;
    assign cnt      = s_q.cnt;
    assign ctl      = s_q.ctl;
    assign txa      = s_q.txa;
    assign rxa      = s_q.rxa;
    assign rxw      = s_q.rxw;
    assign tmr      = s_q.tmr;
    assign retry    = s_q.retry;
    assign tx_valid = s_q.tx_v;
    assign tx_data  = s_q.tx_d;
    assign rx_take  = s_q.rx_take;
    assign ev       = s_q.ev;
endmodule

// File: rtl/tdr_addr_mux.sv
module tdr_addr_mux import tdr_pkg::*; #(
    parameter int AW     = 32,
    parameter int IDX_W  = 8,
    parameter int CNT_W  = 2,
    parameter int TIME_W = 32
) (
    input  seq_state_e        st,
    input  logic [AW-1:0]     ring_base,
    input  logic [IDX_W-1:0]  idx,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [AW-1:0]     txa,
    input  logic [AW-1:0]     rxa,
    input  logic [WORD_W-1:0] rxw,
    input  logic [TIME_W-1:0] tmr,
    input  logic [WORD_W-1:0] ctl,
    input  logic [7:0]        retry,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata
);
    logic [AW-1:0] desc;
    logic [AW-1:0] woff;

    always_comb begin
        desc      = ring_base + (AW'(idx) << 4);
        woff      = AW'(cnt) << 2;
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        case (st)
            S_RD_CTL:  mem_addr = desc + AW'(12);
            S_RD_TXA:  mem_addr = desc + AW'(4);
            S_RD_RXA:  mem_addr = desc + AW'(8);
            S_RD_TX:   mem_addr = txa + woff;
            S_WR_RX: begin
                mem_addr  = rxa + woff;
                mem_we    = 1'b1;
                mem_wdata = rxw;
            end
            S_WR_STAT: begin
                mem_addr  = desc;
                mem_we    = 1'b1;
                mem_wdata = WORD_W'(tmr);
            end
            S_WR_CTL: begin
                mem_addr  = desc + AW'(12);
                mem_we    = 1'b1;
                mem_wdata = {1'b0, ctl[30:16], retry, ctl[7:0]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tdm_ring_dma.sv
module tdm_ring_dma import tdr_pkg::*; #(
    parameter int AW          = 32,
    parameter int REG_AW      = 4,
    parameter int FRAME_WORDS = 4,
    parameter int IDX_W       = 8,
    parameter int TIME_W      = 32,
    localparam int CNT_W      = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              frame_tick,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              tdm_tx_valid,
    output logic [31:0]       tdm_tx_data,
    input  logic [31:0]       tdm_rx_data,
    output logic              tdm_rx_take,
    output logic [1:0]        irq_event
);
    logic              ctl_en, ctl_run, ctl_start, seq_underrun, seq_halt;
    logic [AW-1:0]     ring_base, txa, rxa;
    seq_state_e        st;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] ctl, rxw;
    logic [TIME_W-1:0] tmr;
    logic [7:0]        retry;

    tdr_ctrl_regs #(.AW(AW), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .seq_underrun(seq_underrun), .seq_halt(seq_halt),
        .en(ctl_en), .run(ctl_run), .start(ctl_start), .ring_base(ring_base)
    );

    tdr_seq #(.AW(AW), .FRAME_WORDS(FRAME_WORDS), .IDX_W(IDX_W), .TIME_W(TIME_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(ctl_en), .run(ctl_run), .start(ctl_start),
        .frame_tick(frame_tick), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tdm_rx_data(tdm_rx_data), .st(st), .idx(idx), .cnt(cnt), .ctl(ctl),
        .txa(txa), .rxa(rxa), .rxw(rxw), .tmr(tmr), .retry(retry),
        .tx_valid(tdm_tx_valid), .tx_data(tdm_tx_data), .rx_take(tdm_rx_take),
        .ev(irq_event), .underrun(seq_underrun), .halt(seq_halt), .mem_req(mem_req)
    );

    tdr_addr_mux #(.AW(AW), .IDX_W(IDX_W), .CNT_W(CNT_W), .TIME_W(TIME_W)) u_mux (
        .st(st), .ring_base(ring_base), .idx(idx), .cnt(cnt), .txa(txa), .rxa(rxa),
        .rxw(rxw), .tmr(tmr), .ctl(ctl), .retry(retry),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata)
    );
endmodule

// File: rtl/tdr_checker.sv
module tdr_checker #(
    parameter int AW     = 32,
    parameter int REG_AW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [AW-1:0]     mem_addr,
    input logic [31:0]       mem_wdata,
    input logic [1:0]        irq_event,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              en,
    input logic              run
);
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)))
        else $error("R11 request changed before ack");

    p_underrun_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_event[0] |-> (!en && !run))
        else $error("R7 engine still enabled after underrun");

    p_one_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_event))
        else $error("R5 both events at once");

    p_done_after_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_event[1] |-> $past(mem_req && mem_ack && mem_we && !mem_wdata[31]))
        else $error("R4 done event without owner-cleared write-back");

    p_clksel_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && reg_addr == REG_AW'(4) && $past(reg_addr) == REG_AW'(4))
        |-> ((reg_rdata & 32'h0000_3002) == ($past(reg_rdata) & 32'h0000_3002)))
        else $error("R9 clock field changed while running");

    p_stop_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(run) && !irq_event[0]) |-> !$past(mem_req))
        else $error("R8 running dropped during a frame");

    p_quiet_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !mem_req)
        else $error("R10 memory access while stopped");
endmodule

bind tdm_ring_dma tdr_checker #(.AW(AW), .REG_AW(REG_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq_event(irq_event),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .en(ctl_en), .run(ctl_run)
);

// File: tb/tdm_ring_dma_tb.sv
module tdm_ring_dma_tb;
    localparam int N = 4;
    localparam logic [31:0] OWN = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        frame_tick = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        tdm_tx_valid, tdm_rx_take;
    logic [31:0] tdm_tx_data, tdm_rx_data;
    logic [1:0]  irq_event;

    int total = 0, bad = 0;
    int wait_cfg = 0, wait_cnt = 0;
    int rx_seq = 0, n_done = 0, n_und = 0, req_cycles = 0;
    logic        last_stall = 1'b0, last_we = 1'b0;
    logic [31:0] last_addr = '0, last_wdata = '0;
    logic [31:0] mem [0:1023];
    logic [31:0] txq [$];
    logic [31:0] cur_base = 32'h100;
    logic [31:0] arm_ctl [0:2];
    int rx_first, done_first;

    assign tdm_rx_data = 32'hA500_0000 | 32'(rx_seq);

    always #2.5 clk = ~clk;

    tdm_ring_dma u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_tick(frame_tick),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .tdm_tx_valid(tdm_tx_valid),
        .tdm_tx_data(tdm_tx_data), .tdm_rx_data(tdm_rx_data), .tdm_rx_take(tdm_rx_take),
        .irq_event(irq_event)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // memory model, TDM monitor and event counters
    always @(negedge clk) begin
        if (rst_n) begin
            if (tdm_tx_valid) txq.push_back(tdm_tx_data);
            if (tdm_rx_take) rx_seq++;
            if (irq_event[1]) n_done++;
            if (irq_event[0]) n_und++;
            if (mem_req) req_cycles++;
            if (last_stall) begin
                check("R11 req held", 32'(mem_req), 32'd1);
                check("R11 addr held", mem_addr, last_addr);
                check("R11 data held", {mem_wdata[30:0], mem_we}, {last_wdata[30:0], last_we});
            end
        end
        if (!mem_req) begin
            mem_ack  = 1'b0;
            wait_cnt = wait_cfg;
        end else begin
            if (mem_ack) wait_cnt = wait_cfg;
            if (wait_cnt == 0) begin
                mem_ack = 1'b1;
                if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
                else        mem_rdata = mem[mem_addr[11:2]];
            end else begin
                mem_ack = 1'b0;
                wait_cnt--;
            end
        end
        last_stall = mem_req && !mem_ack;
        last_addr  = mem_addr;
        last_we    = mem_we;
        last_wdata = mem_wdata;
    end

    function automatic logic [31:0] exp_time(input int w);
        return 32'((2 * N + 3) * (w + 1));
    endfunction
    function automatic logic [7:0] exp_retry(input int w);
        int r = (2 * N + 4) * w;
        return (r > 255) ? 8'hFF : 8'(r);
    endfunction
    function automatic logic [31:0] exp_ctl(input logic [31:0] c, input int w);
        return {1'b0, c[30:16], exp_retry(w), c[7:0]};
    endfunction
    function automatic logic [31:0] daddr(input int i);
        return cur_base + 32'(16 * i);
    endfunction

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask
    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask
    task automatic tick();
        @(negedge clk); frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0;
    endtask
    task automatic arm(input int i, input logic [31:0] flags);
        logic [31:0] c;
        c = ($urandom & 32'h7FFF_00FC) | flags | OWN;
        arm_ctl[i] = c;
        mem[daddr(i) >> 2]       = 32'hDEAD_0000 | 32'(i);
        mem[(daddr(i) >> 2) + 1] = 32'h400 + 32'(64 * i);
        mem[(daddr(i) >> 2) + 2] = 32'h800 + 32'(64 * i);
        mem[(daddr(i) >> 2) + 3] = c;
        for (int k = 0; k < N; k++) mem[(32'h400 + 64 * i) / 4 + k] = $urandom;
    endtask
    task automatic start_frame(input int w);
        wait_cfg = w;
        txq.delete();
        rx_first = rx_seq;
        done_first = n_done;
        tick();
    endtask
    task automatic finish_frame(input int i, input int w);
        repeat ((2 * N + 6) * (w + 1) + 6) @(negedge clk);
        check("R4 status time", mem[daddr(i) >> 2], exp_time(w));
        check("R4 control write-back", mem[(daddr(i) >> 2) + 3], exp_ctl(arm_ctl[i], w));
        check("R3 tx count", 32'(txq.size()), 32'(N));
        for (int k = 0; k < N; k++) begin
            check("R3 tx word", (k < txq.size()) ? txq[k] : 32'hX, mem[(32'h400 + 64 * i) / 4 + k]);
            check("R3 rx word", mem[(32'h800 + 64 * i) / 4 + k], 32'hA500_0000 | 32'(rx_first + k));
        end
        check("R5 done events", 32'(n_done - done_first), 32'(arm_ctl[i][1]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int und0, req0;
        void'($urandom(32'd1234));
        for (int k = 0; k < 1024; k++) mem[k] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(4'd0, rd); check("R1 base reset", rd, 32'h0);
        reg_read(4'd4, rd); check("R1 ctrl reset", rd, 32'h0);
        check("R1 no request", 32'(mem_req), 32'h0);
        check("R1 no event", 32'(irq_event), 32'h0);

        // R2/R9 start with slave clock field
        arm(0, 32'h2); arm(1, 32'h0); arm(2, 32'h3);
        reg_write(4'd0, cur_base);
        reg_write(4'd4, 32'h1006);
        reg_read(4'd4, rd); check("R2 running after enable", rd, 32'h100E);
        // R9 field write while running is ignored
        reg_write(4'd4, 32'h2004);
        reg_read(4'd4, rd); check("R9 clock field frozen", rd, 32'h100E);

        // R3..R6 walk the ring twice, random wait states
        for (int f = 0; f < 6; f++) begin
            int w = $urandom_range(0, 3);
            if (f >= 3) arm(f % 3, (f % 3 == 2) ? 32'h3 : ((f % 3 == 0) ? 32'h2 : 32'h0));
            start_frame(w);
            finish_frame(f % 3, w); // R6: index follows the end-of-ring wrap
        end

        // R10 second tick mid-frame is ignored
        arm(0, 32'h2); arm(1, 32'h0);
        start_frame(1);
        repeat (3) @(negedge clk);
        tick();
        finish_frame(0, 1);
        check("R10 next still owned", mem[(daddr(1) >> 2) + 3], arm_ctl[1]);
        check("R10 next status untouched", mem[daddr(1) >> 2], 32'hDEAD_0001);

        // R7 underrun at index 1
        mem[(daddr(1) >> 2) + 3] = arm_ctl[1] & ~OWN;
        und0 = n_und;
        tick();
        repeat (20) @(negedge clk);
        check("R7 underrun event", 32'(n_und - und0), 32'd1);
        reg_read(4'd4, rd); check("R7 stopped", rd, 32'h1002);
        check("R7 no write-back", mem[daddr(1) >> 2], 32'hDEAD_0001);

        // R10 tick while stopped
        req0 = req_cycles;
        tick();
        repeat (20) @(negedge clk);
        check("R10 no access when stopped", 32'(req_cycles - req0), 32'd0);

        // R9 field write while stopped is taken
        reg_write(4'd4, 32'h2000);
        reg_read(4'd4, rd); check("R9 field accepted", rd, 32'h2000);

        // R2 restart at index 0 with a new base
        cur_base = 32'h200;
        arm(0, 32'h2); arm(1, 32'h2); arm(2, 32'h1);
        reg_write(4'd0, cur_base);
        reg_write(4'd4, 32'h2004);
        reg_read(4'd4, rd); check("R2 restarted", rd, 32'h200C);
        start_frame(2);
        finish_frame(0, 2);

        // R8 disable during a frame
        start_frame(1);
        repeat (2) @(negedge clk);
        reg_write(4'd4, 32'h0);
        reg_read(4'd4, rd); check("R8 still running", rd, 32'h2008);
        finish_frame(1, 1);
        reg_read(4'd4, rd); check("R8 stopped after frame", rd, 32'h2000);

        // R4 retry field saturation
        arm(0, 32'h0);
        reg_write(4'd4, 32'h0004);
        start_frame(30);
        finish_frame(0, 30);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule